// File: doc/BRIEF.md
# Stereo Recursive Echo Datapath

This block adds an echo to a continuous stereo audio stream. Each transfer on its input carries one signed sample per channel packed into one word; for every accepted pair it returns one output pair in which each channel's sample is the input plus an attenuated copy of that channel's own output from a fixed number of accepted samples earlier. Because the returned samples are themselves fed back, each echo produces further, quieter echoes: the response is a recursive comb.

The two channels run identical and fully independent loops. Each loop stores its output samples in a delay line whose depth is the smallest power of two holding the delay count. Until the delay line holds that many samples, the loop feeds back zeros. The stored sample is multiplied by a fixed-point gain, narrowed back to sample width, added to the incoming sample, and the sum is narrowed again. The delay count and the gain are compile-time parameters; the delay count is the delay time multiplied by the sample rate (4800 samples for 100 ms at 48 kHz, for example).

Both channels share one valid/ready handshake on each side. A single output register holds the result pair, so the block accepts a new pair whenever that register is empty or being emptied in the same cycle.

Top module: `stereo_echo_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is low and `in_ready` is high; reset empties both delay lines and restarts the zero-feedback count, so the output after reset is the same as after power-up.
- R2: For the first `DELAY_LEN` pairs accepted after reset, each output sample equals the corresponding input sample (feedback is zero).
- R3: For accepted pair n with n >= `DELAY_LEN`, each channel output is y[n] = wrap16(x[n] + scale(y[n - `DELAY_LEN`])), where n counts accepted pairs only.
- R4: scale(s) forms the 32-bit signed product s * `GAIN` (both operands q1.15) and keeps product bits 30 down to 15; low bits are discarded (rounding toward minus infinity) and bit 31 is dropped.
- R5: The sum of the input and the scaled feedback keeps only its low 16 bits (wraps modulo 2^16, no saturation); for example 32767 + 19660 gives -13109 and -32768 + (-19661) gives 13107.
- R6: Channel 0 uses data bits 15:0 and channel 1 uses bits 31:16 on both input and output; neither channel's output depends on the other channel's samples.
- R7: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high; a pair is taken when `in_valid` and `in_ready` are both high, and its result appears on `out_data` with `out_valid` high in the next cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: Cycles in which no pair is accepted do not advance either loop: `in_data` is ignored and the delay counts only accepted pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair is present |
| in_ready | output | 1 | Block can take an input pair this cycle |
| in_data | input | 32 | Input pair: channel 1 in 31:16, channel 0 in 15:0, signed q1.15 |
| out_valid | output | 1 | Output pair is present |
| out_ready | input | 1 | Consumer takes the output pair this cycle |
| out_data | output | 32 | Output pair, same layout as `in_data` |

## Verification
The bench builds the block with a delay of 3 samples (a 4-entry delay line) and the nominal gain of 19661, so the zero-feedback phase ends after three pairs and every pointer wrap of the delay line occurs many times within a few hundred accepted pairs. With so short a delay, full-scale inputs reach the recursive region at once, which brings the wrap-around sums and the negative-product truncation into reach with directed values. Random gaps on the input and random back-pressure on the output exercise the hold rule and show that idle cycles do not move the echo, and a reset in mid-stream checks that priming starts over.

// File: rtl/stereo_echo_pkg.sv
package stereo_echo_pkg;

    localparam int SAMPLE_W = 16;
    localparam int CHANNELS = 2;
    localparam int PAIR_W   = SAMPLE_W * CHANNELS;
    localparam int PROD_W   = 2 * SAMPLE_W;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [PROD_W-1:0]   product_t;
    typedef logic signed [SAMPLE_W:0]   wide_sum_t;

    typedef struct packed {
        sample_t ch1;
        sample_t ch0;
    } pair_t;

    // q1.15 * q1.15 -> q2.30, keep bits 30..15 to return to q1.15
    function automatic sample_t scale_q15(sample_t s, sample_t g);
        product_t p;
        p = product_t'(s) * product_t'(g);
        return p[PROD_W-2:SAMPLE_W-1];
    endfunction

    // q1.15 + q1.15 -> q2.15, drop the extra integer bit (wraps)
    function automatic sample_t add_wrap(sample_t a, sample_t b);
        wide_sum_t s;
        s = wide_sum_t'(a) + wide_sum_t'(b);
        return s[SAMPLE_W-1:0];
    endfunction

    // address width of the smallest power-of-two store holding n entries
    function automatic int store_aw(int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/echo_delay_line.sv
module echo_delay_line
    import stereo_echo_pkg::*;
#(
    parameter int DELAY_LEN = 4800,
    parameter int AW        = store_aw(DELAY_LEN),
    parameter int DEPTH     = 1 << AW
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    step,
    input  sample_t wr_sample,
    output sample_t fb_sample
);

    localparam int CW = $clog2(DELAY_LEN + 1);

    sample_t         store [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   fill_cnt;
    logic            primed;

    assign primed    = (fill_cnt == CW'(DELAY_LEN));
    assign fb_sample = primed ? store[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill_cnt <= '0;
        end else if (step) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (primed) begin
                rd_ptr <= rd_ptr + 1'b1;
            end else begin
                fill_cnt <= fill_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (step) begin
            store[wr_ptr] <= wr_sample;
        end
    end

endmodule

// File: rtl/echo_channel.sv
module echo_channel
    import stereo_echo_pkg::*;
#(
    parameter int      DELAY_LEN = 4800,
    parameter sample_t GAIN      = sample_t'(19661)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    step,
    input  sample_t x_in,
    output sample_t y_out
);

    sample_t delayed;
    sample_t attenuated;

    assign attenuated = scale_q15(delayed, GAIN);
    assign y_out      = add_wrap(x_in, attenuated);

    echo_delay_line #(
        .DELAY_LEN (DELAY_LEN)
    ) delay_i (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .wr_sample (y_out),
        .fb_sample (delayed)
    );

endmodule

// File: rtl/stereo_echo_top.sv
module stereo_echo_top
    import stereo_echo_pkg::*;
#(
    parameter int DELAY_LEN = 480,
    parameter int GAIN      = 19661
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PAIR_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PAIR_W-1:0] out_data
);

    logic                     take;
    logic [PAIR_W-1:0]        result;
    pair_t                    out_q;

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        echo_channel #(
            .DELAY_LEN (DELAY_LEN),
            .GAIN      (sample_t'(GAIN))
        ) chan_i (
            .clk   (clk),
            .rst   (rst),
            .step  (take),
            .x_in  (in_data[c*SAMPLE_W +: SAMPLE_W]),
            .y_out (result[c*SAMPLE_W +: SAMPLE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_q     <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_q     <= pair_t'(result);
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign out_data = out_q;

endmodule

// File: rtl/stereo_echo_chk.sv
module stereo_echo_chk
    import stereo_echo_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [PAIR_W-1:0] out_data
);

    a_r1_reset_empties: assert property (@(posedge clk)
        rst |=> !out_valid);

    a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    a_r7_take_loads: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    a_r7_drain_clears: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind stereo_echo_top stereo_echo_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/stereo_echo_top_tb_top.sv
module stereo_echo_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int D          = 3;
    localparam int G          = 19661;
    localparam int MAXN       = 1024;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;

    stereo_echo_top #(.DELAY_LEN(D), .GAIN(G)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;

    logic signed [15:0] ys [2][MAXN];
    int                 n_in = 0;
    logic [31:0]        exp_q [$];
    string              req_q [$];
    logic [31:0]        got [MAXN];
    int                 n_out = 0;
    bit                 prev_stall = 0;
    logic [31:0]        held;
    logic [31:0]        lfsr = 32'h1ACE_B00C;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic signed [15:0] model(input int ch, input logic signed [15:0] x, input int n);
        int p;
        int t;
        if (n < D) return x;
        p = int'(ys[ch][n-D]) * G;
        t = p >>> 15;
        return 16'(int'(x) + int'(16'(t)));
    endfunction

    function automatic logic [31:0] step_lfsr(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    task automatic cycle(input bit iv, input logic [31:0] d, input bit ordy);
        logic signed [15:0] y0;
        logic signed [15:0] y1;
        @(negedge clk);
        in_valid  = iv;
        in_data   = d;
        out_ready = ordy;
        #1;
        if (prev_stall) begin
            check(out_valid && out_data == held, "R8", out_data, held);
        end
        check(in_ready == (!out_valid || out_ready), "R7", {31'd0, in_ready},
              {31'd0, (!out_valid || out_ready)});
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", out_data, 32'hx);
            end else begin
                logic [31:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(out_data == e, r, out_data, e);
                if (n_out < MAXN) got[n_out] = out_data;
                n_out = n_out + 1;
            end
        end
        if (in_valid && in_ready) begin
            y0 = model(0, d[15:0], n_in);
            y1 = model(1, d[31:16], n_in);
            ys[0][n_in] = y0;
            ys[1][n_in] = y1;
            exp_q.push_back({y1, y0});
            req_q.push_back(n_in < D ? "R2/R6" : "R3/R4/R6/R9");
            n_in = n_in + 1;
        end
        prev_stall = out_valid && !out_ready;
        held       = out_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid, "R1", {31'd0, out_valid}, 32'd0);
        check(in_ready, "R1", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!out_valid && in_ready, "R1", {30'd0, out_valid, in_ready}, 32'd1);
        n_in = 0;
        n_out = 0;
        exp_q.delete();
        req_q.delete();
        prev_stall = 0;
        @(posedge clk);
    endtask

    initial begin
        do_reset();

        // ramp on channel 0, falling negative ramp on channel 1, full rate
        for (int i = 0; i < 40; i++) begin
            cycle(1'b1, {16'(-(i * 700) - 5), 16'(i * 900 + 11)}, 1'b1);
        end

        // random gaps, random back-pressure, random data
        for (int i = 0; i < 400; i++) begin
            lfsr = step_lfsr(lfsr);
            cycle(lfsr[3] | lfsr[7], {lfsr[15:0] ^ 16'h5A5A, lfsr[31:16]}, lfsr[5] | lfsr[9]);
        end

        // drain, then reset in mid-echo: priming restarts
        for (int i = 0; i < 6; i++) cycle(1'b0, 32'hDEAD_BEEF, 1'b1);
        check(exp_q.size() == 0, "R7", exp_q.size(), 32'd0);
        do_reset();

        // full-scale inputs: wrap-around sums and negative truncation
        for (int i = 0; i < 12; i++) begin
            cycle(1'b1, {16'sh8000, 16'sh7FFF}, 1'b1);
        end
        for (int i = 0; i < 4; i++) cycle(1'b0, 32'h0, 1'b1);
        check(got[0] == 32'h8000_7FFF, "R1/R2", got[0], 32'h8000_7FFF);
        check(got[2] == 32'h8000_7FFF, "R2", got[2], 32'h8000_7FFF);
        check(got[3][15:0] == 16'hCCCB, "R5", {16'd0, got[3][15:0]}, 32'h0000_CCCB);
        check(got[3][31:16] == 16'h3333, "R4/R5", {16'd0, got[3][31:16]}, 32'h0000_3333);

        // idle cycles with garbage data must not move the echo, then one sample
        for (int i = 0; i < 20; i++) cycle(1'b0, 32'h1234_5678 + i, 1'b1);
        cycle(1'b1, 32'h0000_0000, 1'b1);
        cycle(1'b0, 32'h0, 1'b1);
        check(exp_q.size() == 0, "R9", exp_q.size(), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule